// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address into a physical address by searching a hashed page table held in memory. Sixteen segment registers, loaded through a write port, each supply a segment identifier. The top nibble of the address picks one of them. The walker hashes that identifier with the page index and then reads candidate entries one word at a time through a simple read port. It searches a primary group of eight entries first. If none of them matches, it searches a secondary group found through the complemented hash.

A request is taken only while the walker is idle. It ends in a one-cycle response that carries one of two results. On a match, the response gives the physical address. When no entry matches, or the page-table register is zero, it gives a translation fault with status bits and the faulting address. The page-table register holds the 64 KiB-aligned table origin in bits [31:16] and the size mask in bits [8:0]. The table spans (1 + mask) × 64 KiB.

Top module: `hpt_walker`

## Requirements
- R1: `reqReady` is high only while idle. A request is accepted on a cycle where `reqValid` and `reqReady` are both high. While a walk is in progress, `reqValid` is ignored, and no memory read is issued while idle.
- R2: Address bits [31:28] select the segment register. The segment identifier is the low 24 bits of that register, and its upper 8 bits have no effect.
- R3: The primary hash is address bits [27:12] XOR the segment identifier, truncated to 23 bits. The group address is origin + (((hash[22:10] AND mask) << 16) OR (hash[9:0] << 6)). Entry i of a group is read at group + 8·i, and every read address is word aligned.
- R4: The first word of an entry must equal the expected key exactly. The key is bit 31 set, the segment identifier in bits [30:7], the group-select bit in bit 6 (0 for primary), and address bits [27:22] in bits [5:0]. The scan stops at the first match and then reads the second word at entry + 4.
- R5: The secondary group is searched only after all eight primary entries miss. It uses the 23-bit complement of the primary hash, and its key has bit 6 set.
- R6: On a match, `rspFault` is 0, `rspStatus` is 0, and `rspPhysAddr` is {second word [31:12], address [11:0]}.
- R7: If all sixteen entries miss, the walker reports a fault after exactly sixteen key reads. `rspStatus` bit 0 (no translation) is set, `rspStatus` bit 1 equals the store flag, and `rspFaultAddr` is the request address.
- R8: A zero page-table register produces a fault with `rspStatus` = 2'b01 (for a load) and no memory read at all.
- R9: A nonzero mask brings hash bits [22:10] into address bits 16 and up of the group offset.
- R10: Only one read is outstanding at a time. `memRdReq` and `memRdAddr` stay unchanged until `memRdValid`, for any read latency.
- R11: A segment-register write in the same cycle as a request acceptance does not affect that request, which uses the previous contents. Later requests see the new value.
- R12: `rspValid` is a single-cycle pulse, and the walker is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 32 | Effective address to translate |
| reqStore | input | 1 | Request is a store |
| reqReady | output | 1 | Walker idle, request may be accepted |
| tableCfg | input | 32 | Table origin [31:16], size mask [8:0] |
| segWrEn | input | 1 | Segment register write enable |
| segWrIdx | input | 4 | Segment register index |
| segWrData | input | 32 | Segment register write data |
| memRdReq | output | 1 | Memory word read request |
| memRdAddr | output | 32 | Memory read byte address |
| memRdValid | input | 1 | Read data valid, completes the read |
| memRdData | input | 32 | Read data word |
| rspValid | output | 1 | Response pulse |
| rspFault | output | 1 | Translation fault |
| rspStatus | output | 2 | Bit 0 no translation, bit 1 store |
| rspPhysAddr | output | 32 | Translated physical address |
| rspFaultAddr | output | 32 | Faulting effective address |

## Verification
A segment-register write can land on the same clock edge that a request is accepted, and that request has to hash with the register's old contents. The bench drives both inputs in the same cycle. The table holds a matching entry for the old identifier and another for the new one, each with a different page, so the returned page shows which identifier was used. A second request then has to return the other page. The bench also keeps `reqValid` raised with a different address during a walk and checks that only the first request is answered.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FETCH = 2'd2,
    ST_RESP  = 2'd3
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request, clear group select and index
    logic idxInc;     // advance to next entry in group
    logic goSec;      // switch to secondary group, restart index
    logic wordSel;    // 0: key word, 1: page word
    logic rpnLoad;    // capture page word
    logic faultLoad;  // mark response as fault
  } walkStrobe_t;

endpackage

// File: rtl/hptw_dp.sv
module hptw_dp
  import hptw_pkg::*;
#(
  parameter int VSID_W      = 24,
  parameter int MASK_W      = 9,
  parameter int GRP_ENTRIES = 8,
  parameter int SEG_CNT     = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  walkStrobe_t strobe,
  input  logic [31:0] reqAddr,
  input  logic        reqStore,
  input  logic [31:0] tableCfg,
  input  logic        segWrEn,
  input  logic [$clog2(SEG_CNT)-1:0] segWrIdx,
  input  logic [31:0] segWrData,
  input  logic [31:0] memRdData,
  output logic [31:0] memRdAddr,
  output logic        keyMatch,
  output logic        idxLast,
  output logic        secActive,
  output logic        cfgZeroIn,
  output logic        rspFault,
  output logic [1:0]  rspStatus,
  output logic [31:0] rspPhysAddr,
  output logic [31:0] rspFaultAddr
);

  localparam int SEG_IDX_W  = $clog2(SEG_CNT);
  localparam int PAGE_SHIFT = 12;
  localparam int PIDX_W     = 28 - PAGE_SHIFT;
  localparam int HASH_W     = 23;
  localparam int LOW_W      = 10;
  localparam int HI_W       = HASH_W - LOW_W;
  localparam int PTE_BYTES  = 8;
  localparam int ENT_SHIFT  = $clog2(PTE_BYTES);
  localparam int GRP_SHIFT  = $clog2(GRP_ENTRIES * PTE_BYTES);
  localparam int TBL_SHIFT  = LOW_W + GRP_SHIFT;
  localparam int IDX_W      = $clog2(GRP_ENTRIES);
  localparam int API_W      = 6;

  // segment register file
  logic [VSID_W-1:0] segQ [SEG_CNT];
  logic [SEG_CNT-1:0] segHit;

  for (genvar g = 0; g < SEG_CNT; g++) begin : gSegDec
    assign segHit[g] = segWrEn && (segWrIdx == SEG_IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_CNT; i++) segQ[i] <= '0;
    end else begin
      for (int i = 0; i < SEG_CNT; i++)
        if (segHit[i]) segQ[i] <= segWrData[VSID_W-1:0];
    end
  end

  // request context
  logic [31:0]       addrQ;
  logic              storeQ;
  logic [VSID_W-1:0] vsidQ;
  logic [31:0]       cfgQ;
  logic              secQ;
  logic [IDX_W-1:0]  idxQ;
  logic [31:0]       rpnWordQ;
  logic              faultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      storeQ   <= 1'b0;
      vsidQ    <= '0;
      cfgQ     <= '0;
      secQ     <= 1'b0;
      idxQ     <= '0;
      rpnWordQ <= '0;
      faultQ   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        addrQ  <= reqAddr;
        storeQ <= reqStore;
        vsidQ  <= segQ[reqAddr[31:32-SEG_IDX_W]];
        cfgQ   <= tableCfg;
        secQ   <= 1'b0;
        idxQ   <= '0;
        faultQ <= strobe.faultLoad;
      end else begin
        if (strobe.faultLoad) faultQ <= 1'b1;
        if (strobe.goSec) begin
          secQ <= 1'b1;
          idxQ <= '0;
        end else if (strobe.idxInc) begin
          idxQ <= idxQ + 1'b1;
        end
        if (strobe.rpnLoad) rpnWordQ <= memRdData;
      end
    end
  end

  // hash and group address
  logic [PIDX_W-1:0] pageIdx;
  logic [VSID_W-1:0] mixed;
  logic [HASH_W-1:0] hashPri;
  logic [HASH_W-1:0] hashCur;
  logic [HI_W-1:0]   hiSel;
  logic [31:0]       grpOffset;
  logic [31:0]       grpBase;
  logic [31:0]       entryOff;
  logic [31:0]       expKey;

  always_comb begin
    pageIdx   = addrQ[27:PAGE_SHIFT];
    mixed     = VSID_W'(pageIdx) ^ vsidQ;
    hashPri   = mixed[HASH_W-1:0];
    hashCur   = secQ ? ~hashPri : hashPri;
    hiSel     = hashCur[HASH_W-1:LOW_W] & HI_W'(cfgQ[MASK_W-1:0]);
    grpOffset = (32'(hiSel) << TBL_SHIFT) | (32'(hashCur[LOW_W-1:0]) << GRP_SHIFT);
    grpBase   = {cfgQ[31:TBL_SHIFT], TBL_SHIFT'(0)} + grpOffset;
    entryOff  = (32'(idxQ) << ENT_SHIFT) + (strobe.wordSel ? 32'd4 : 32'd0);
    memRdAddr = grpBase + entryOff;
    expKey    = {1'b1, vsidQ, secQ, addrQ[27:28-API_W]};
  end

  assign keyMatch  = (memRdData == expKey);
  assign idxLast   = (idxQ == IDX_W'(GRP_ENTRIES - 1));
  assign secActive = secQ;
  assign cfgZeroIn = (tableCfg == '0);

  assign rspFault     = faultQ;
  assign rspStatus    = faultQ ? {storeQ, 1'b1} : 2'b00;
  assign rspPhysAddr  = {rpnWordQ[31:PAGE_SHIFT], addrQ[PAGE_SHIFT-1:0]};
  assign rspFaultAddr = addrQ;

endmodule

// File: rtl/hptw_ctrl.sv
module hptw_ctrl
  import hptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  input  logic        keyMatch,
  input  logic        idxLast,
  input  logic        secActive,
  input  logic        cfgZeroIn,
  output walkStrobe_t strobe,
  output logic        reqReady,
  output logic        memRdReq,
  output logic        rspValid
);

  walkState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    reqReady = 1'b0;
    memRdReq = 1'b0;
    rspValid = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (cfgZeroIn) begin
            strobe.faultLoad = 1'b1;
            stateD = ST_RESP;
          end else begin
            stateD = ST_SCAN;
          end
        end
      end
      ST_SCAN: begin
        memRdReq = 1'b1;
        if (memRdValid) begin
          if (keyMatch) begin
            stateD = ST_FETCH;
          end else if (idxLast) begin
            if (secActive) begin
              strobe.faultLoad = 1'b1;
              stateD = ST_RESP;
            end else begin
              strobe.goSec = 1'b1;
            end
          end else begin
            strobe.idxInc = 1'b1;
          end
        end
      end
      ST_FETCH: begin
        memRdReq       = 1'b1;
        strobe.wordSel = 1'b1;
        if (memRdValid) begin
          strobe.rpnLoad = 1'b1;
          stateD = ST_RESP;
        end
      end
      ST_RESP: begin
        rspValid = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hptw_pkg::*;
#(
  parameter int VSID_W      = 24,
  parameter int MASK_W      = 9,
  parameter int GRP_ENTRIES = 8,
  parameter int SEG_CNT     = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic        reqStore,
  output logic        reqReady,
  input  logic [31:0] tableCfg,
  input  logic        segWrEn,
  input  logic [3:0]  segWrIdx,
  input  logic [31:0] segWrData,
  output logic        memRdReq,
  output logic [31:0] memRdAddr,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  output logic        rspValid,
  output logic        rspFault,
  output logic [1:0]  rspStatus,
  output logic [31:0] rspPhysAddr,
  output logic [31:0] rspFaultAddr
);

  walkStrobe_t strobe;
  logic keyMatch, idxLast, secActive, cfgZeroIn;

  hptw_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .keyMatch   (keyMatch),
    .idxLast    (idxLast),
    .secActive  (secActive),
    .cfgZeroIn  (cfgZeroIn),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .memRdReq   (memRdReq),
    .rspValid   (rspValid)
  );

  hptw_dp #(
    .VSID_W      (VSID_W),
    .MASK_W      (MASK_W),
    .GRP_ENTRIES (GRP_ENTRIES),
    .SEG_CNT     (SEG_CNT)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqStore     (reqStore),
    .tableCfg     (tableCfg),
    .segWrEn      (segWrEn),
    .segWrIdx     (segWrIdx),
    .segWrData    (segWrData),
    .memRdData    (memRdData),
    .memRdAddr    (memRdAddr),
    .keyMatch     (keyMatch),
    .idxLast      (idxLast),
    .secActive    (secActive),
    .cfgZeroIn    (cfgZeroIn),
    .rspFault     (rspFault),
    .rspStatus    (rspStatus),
    .rspPhysAddr  (rspPhysAddr),
    .rspFaultAddr (rspFaultAddr)
  );

endmodule

// File: rtl/hptw_chk.sv
module hptw_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        memRdReq,
  input logic [31:0] memRdAddr,
  input logic        memRdValid,
  input logic        rspValid,
  input logic        rspFault,
  input logic [1:0]  rspStatus
);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memRdReq);

  p_word_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (memRdAddr[1:0] == 2'b00));

  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdValid) |=> (memRdReq && $stable(memRdAddr)));

  p_fault_status_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspStatus[0]);

  p_hit_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspStatus == 2'b00));

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

endmodule

bind hpt_walker hptw_chk i_hptw_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .memRdReq   (memRdReq),
  .memRdAddr  (memRdAddr),
  .memRdValid (memRdValid),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspStatus  (rspStatus)
);

// File: tb/test_hpt_walker.sv
module test_hpt_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqStore = 1'b0;
  logic        reqReady;
  logic [31:0] tableCfg = 32'h0010_0000;
  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [31:0] segWrData = '0;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        rspValid;
  logic        rspFault;
  logic [1:0]  rspStatus;
  logic [31:0] rspPhysAddr;
  logic [31:0] rspFaultAddr;

  hpt_walker i_hpt_walker (.*);

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int lat = 0;
  int nReads = 0;
  logic [31:0] rdLog [64];
  logic [31:0] mem [logic [31:0]];
  logic [31:0] gotPhys, gotFaultAddr;
  logic        gotFault;
  logic [1:0]  gotStatus;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] hashOf(input logic [23:0] vsid, input logic [31:0] a, input bit sec);
    logic [23:0] t;
    t = {8'h00, a[27:12]} ^ vsid;
    return sec ? ~t[22:0] : t[22:0];
  endfunction

  function automatic logic [31:0] grpOf(input logic [23:0] vsid, input logic [31:0] a, input bit sec, input logic [31:0] cfg);
    logic [22:0] h;
    logic [31:0] hi;
    h  = hashOf(vsid, a, sec);
    hi = {19'd0, h[22:10]} & {23'd0, cfg[8:0]};
    return {cfg[31:16], 16'h0000} + ((hi << 16) | ({22'd0, h[9:0]} << 6));
  endfunction

  function automatic logic [31:0] keyOf(input logic [23:0] vsid, input logic [31:0] a, input bit sec);
    return {1'b1, vsid, sec, a[27:22]};
  endfunction

  // memory model: answers after lat idle cycles, one read at a time
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (memRdValid) begin
        memRdValid = 1'b0;
        cnt = 0;
      end else if (memRdReq) begin
        if (cnt >= lat) begin
          memRdValid = 1'b1;
          memRdData  = mem.exists(memRdAddr) ? mem[memRdAddr] : 32'h0;
          if (nReads < 64) rdLog[nReads] = memRdAddr;
          nReads++;
        end else begin
          cnt++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic segWrite(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrData = d;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic putPte(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a] = w0;
    mem[a + 4] = w1;
  endtask

  task automatic waitRsp();
    int guard;
    guard = 0;
    while (!rspValid && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    chk(rspValid, "R12 response seen", {31'd0, rspValid}, 32'd1);
    gotFault = rspFault; gotStatus = rspStatus;
    gotPhys = rspPhysAddr; gotFaultAddr = rspFaultAddr;
    @(negedge clk);
    chk(!rspValid && reqReady, "R12 single pulse then ready", {30'd0, rspValid, reqReady}, 32'd1);
  endtask

  task automatic runReq(input logic [31:0] a, input bit st);
    nReads = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqStore = st;
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp();
  endtask

  task automatic tReset();
    chk(reqReady, "R1 ready after reset", {31'd0, reqReady}, 32'd1);
    chk(!memRdReq && !rspValid, "R1 quiet after reset", {30'd0, memRdReq, rspValid}, 32'd0);
  endtask

  task automatic tPrimaryHit();
    logic [31:0] a, g;
    logic [23:0] v;
    mem.delete(); lat = 0;
    tableCfg = 32'h0010_0000;
    a = 32'h3ABC_D123; v = 24'hFF_0123;
    segWrite(4'd3, 32'hAA00_0000 | {8'h00, v});   // R2 upper bits ignored
    g = grpOf(v, a, 1'b0, tableCfg);
    putPte(g, keyOf(v, a, 1'b0) & 32'h7FFF_FFFF, 32'hDEAD_B000);
    putPte(g + 16, keyOf(v, a, 1'b0), 32'h1234_5ABC);
    putPte(g + 24, keyOf(v, a, 1'b0), 32'h7777_7000);
    runReq(a, 1'b0);
    chk(!gotFault, "R4 hit no fault", {31'd0, gotFault}, 32'd0);
    chk(gotPhys == 32'h1234_5123, "R6 phys address", gotPhys, 32'h1234_5123);
    chk(gotStatus == 2'b00, "R6 status clear", {30'd0, gotStatus}, 32'd0);
    chk(nReads == 4, "R4 stops at first match", nReads, 4);
    chk(rdLog[0] == g, "R3 primary group address", rdLog[0], g);
    chk(rdLog[2] == g + 16, "R3 entry stride", rdLog[2], g + 16);
    chk(rdLog[3] == g + 20, "R4 page word read", rdLog[3], g + 20);
  endtask

  task automatic tSecondaryHit();
    logic [31:0] a, gp, gs;
    logic [23:0] v;
    mem.delete(); lat = 2;                        // R10 slow memory
    a = 32'h3123_4FFF; v = 24'hFF_0123;
    gp = grpOf(v, a, 1'b0, tableCfg);
    gs = grpOf(v, a, 1'b1, tableCfg);
    for (int i = 0; i < 8; i++) putPte(gp + 8*i, keyOf(v, a, 1'b1), 32'h1111_1000);
    putPte(gs, keyOf(v, a, 1'b0), 32'h2222_2000);
    putPte(gs + 40, keyOf(v, a, 1'b1), 32'h0BEE_F000);
    runReq(a, 1'b0);
    chk(!gotFault, "R5 secondary hit", {31'd0, gotFault}, 32'd0);
    chk(gotPhys == 32'h0BEE_FFFF, "R5 secondary phys", gotPhys, 32'h0BEE_FFFF);
    chk(nReads == 15, "R5 read count", nReads, 15);
    chk(rdLog[8] == gs, "R5 secondary group address", rdLog[8], gs);
    chk(rdLog[14] == gs + 44, "R10 page word after latency", rdLog[14], gs + 44);
  endtask

  task automatic tMiss(input bit st);
    logic [31:0] a, gs;
    logic [23:0] v;
    mem.delete(); lat = 1;
    a = 32'h3FED_C004; v = 24'hFF_0123;
    gs = grpOf(v, a, 1'b1, tableCfg);
    runReq(a, st);
    chk(gotFault, "R7 fault on double miss", {31'd0, gotFault}, 32'd1);
    chk(gotStatus == {st, 1'b1}, "R7 fault status", {30'd0, gotStatus}, {30'd0, st, 1'b1});
    chk(gotFaultAddr == a, "R7 fault address", gotFaultAddr, a);
    chk(nReads == 16, "R7 sixteen key reads", nReads, 16);
    chk(rdLog[15] == gs + 56, "R7 last secondary entry", rdLog[15], gs + 56);
  endtask

  task automatic tZeroCfg();
    mem.delete(); lat = 0;
    tableCfg = 32'h0;
    runReq(32'h3000_1000, 1'b0);
    chk(gotFault && gotStatus == 2'b01, "R8 fault on zero table", {30'd0, gotStatus}, 32'd1);
    chk(nReads == 0, "R8 no memory read", nReads, 0);
    tableCfg = 32'h0010_0000;
  endtask

  task automatic tMask();
    logic [31:0] a, g;
    logic [23:0] v;
    mem.delete(); lat = 0;
    tableCfg = 32'h0020_0003;
    a = 32'h7C00_3456; v = 24'h00_0C00;
    segWrite(4'd7, {8'h00, v});
    g = grpOf(v, a, 1'b0, tableCfg);
    chk(g[17:16] != 2'b00, "R9 mask selects high hash bits", g, 32'h0);
    putPte(g, keyOf(v, a, 1'b0), 32'h00AB_C000);
    runReq(a, 1'b0);
    chk(rdLog[0] == g, "R9 masked group address", rdLog[0], g);
    chk(gotPhys == 32'h00AB_C456, "R9 phys", gotPhys, 32'h00AB_C456);
    tableCfg = 32'h0010_0000;
  endtask

  task automatic tBusy();
    logic [31:0] a, g;
    logic [23:0] v;
    int extra;
    mem.delete(); lat = 5;
    a = 32'h3000_0010; v = 24'hFF_0123;
    g = grpOf(v, a, 1'b0, tableCfg);
    putPte(g, keyOf(v, a, 1'b0), 32'h5555_5000);
    nReads = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqStore = 1'b0;
    @(negedge clk);
    reqAddr = 32'h3999_9990;
    while (!rspValid) begin
      chk(!reqReady, "R1 busy not ready", {31'd0, reqReady}, 32'd0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    gotPhys = rspPhysAddr;
    chk(gotPhys == 32'h5555_5010, "R1 first request answered", gotPhys, 32'h5555_5010);
    extra = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rspValid || memRdReq) extra++;
    end
    chk(extra == 0, "R1 request during walk ignored", extra, 0);
  endtask

  task automatic tSegRace();
    logic [31:0] a;
    logic [23:0] v1, v2;
    mem.delete(); lat = 0;
    a = 32'h5012_3678; v1 = 24'h00_0111; v2 = 24'h00_0222;
    segWrite(4'd5, {8'h00, v1});
    putPte(grpOf(v1, a, 1'b0, tableCfg), keyOf(v1, a, 1'b0), 32'hAAAA_A000);
    putPte(grpOf(v2, a, 1'b0, tableCfg), keyOf(v2, a, 1'b0), 32'hBBBB_B000);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqStore = 1'b0;
    segWrEn = 1'b1; segWrIdx = 4'd5; segWrData = {8'h00, v2};
    @(negedge clk);
    reqValid = 1'b0; segWrEn = 1'b0;
    waitRsp();
    chk(gotPhys == 32'hAAAA_A678, "R11 old segment used", gotPhys, 32'hAAAA_A678);
    runReq(a, 1'b0);
    chk(gotPhys == 32'hBBBB_B678, "R11 new segment later", gotPhys, 32'hBBBB_B678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tPrimaryHit();
    tSecondaryHit();
    tMiss(1'b1);
    tMiss(1'b0);
    tZeroCfg();
    tMask();
    tBusy();
    tSegRace();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule